// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early Warning

This block is an independent watchdog for a system that must prove it is still alive. A small synchronous register port holds the configuration. Magic values written to a key register start the timer, reload it, and open or close write access to the configuration registers. Once the timer is started, a programmable prescaler divides the clock into ticks. Each tick decrements a 12-bit counter. When the count passes zero, the block emits a one-cycle reset pulse and then reloads itself.

An early-warning comparator sets a flag when the counter reaches a programmed compare value. If the warning enable is set, the flag also drives an interrupt, so software gets a chance to react before the reset fires. The counter sits in a slow clock domain, and configuration writes take time to reach it. That crossing is modelled as a fixed delay of LAT cycles per field. While a field's new value is on its way, its busy flag in the status register is set.

All reads are registered: read data appears in the cycle after `rd_en_i` is sampled. Unmapped addresses read 0.

Top module: `wdg_top`

## Requirements
- R1: After reset, the block has these values: status reads 0, the reload register reads 0xFFF, prescaler and early-warning registers read 0, both outputs are low, and the timer is stopped.
- R2: Writing 0xCCCC to the key register (0x00) starts the timer and loads the counter from the active reload value; status bit 8 then reads 1.
- R3: Once running, the reset output pulses high for exactly one cycle, (reload+1)*div cycles after the start edge. The counter then reloads, and the same period repeats.
- R4: The prescaler register (0x04) code c selects division by 4<<c; any code of 6 or more divides by 256.
- R5: Writing 0xAAAA to the key register reloads the counter and restarts the prescaler phase, so the next reset comes (reload+1)*div cycles after that write.
- R6: Writing 0x5555 to the key register opens the prescaler, reload (0x08) and early-warning (0x14) registers; writing 0x0000 closes them. While closed, writes to those registers change no value and set no busy flag.
- R7: An accepted write to the prescaler, reload, compare or enable field sets status bit 0, 1, 2 or 3 respectively. The bit stays set for LAT cycles, and the new value is used by the timer only after that. A reload key given while the reload field is busy still uses the old value.
- R8: When a tick moves the counter onto the compare value (early-warning bits 11:0), the warning flag (status bit 15) sets. The interrupt output follows the flag only while the enable (early-warning bit 15) is 1.
- R9: Writing 1 to early-warning bit 14 clears the warning flag, even while the registers are closed. Writing 1 to bit 15 of the clear register (0x18) also clears it.
- R10: A write to the early-warning register while open reloads the counter. A write to it while closed does not.
- R11: No register write stops a running timer; only the block reset does.
- R12: The version register (0x3F4) reads 0x40 in its low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| wdg_rst_o | output | 1 | One-cycle reset pulse on expiry |
| ew_irq_o | output | 1 | Early-warning interrupt |

## Verification
The assertions check four properties on every cycle:
- the reset pulse never lasts two cycles;
- a started timer never drops out of the running state;
- a write made while the registers are closed never raises a busy flag;
- the interrupt is never high without the warning flag, and a settled field always holds its shadow value.

Other behaviour can only be shown by the bench's scenarios. The exact reset period for each prescaler code and reload value, and the cycle at which the warning hits, are measured from the start edge. The bench also covers the stale reload used while the reload field is busy, and the reload effect of an early-warning write made while open versus closed.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_KEY  = 12'h000;
  localparam logic [ADDR_W-1:0] A_PRE  = 12'h004;
  localparam logic [ADDR_W-1:0] A_RLD  = 12'h008;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] A_EW   = 12'h014;
  localparam logic [ADDR_W-1:0] A_CLR  = 12'h018;
  localparam logic [ADDR_W-1:0] A_VER  = 12'h3F4;

  localparam logic [15:0] K_LOCK   = 16'h0000;
  localparam logic [15:0] K_OPEN   = 16'h5555;
  localparam logic [15:0] K_RELOAD = 16'hAAAA;
  localparam logic [15:0] K_START  = 16'hCCCC;

  // field indices of the delayed configuration fields
  localparam int F_PRE = 0;
  localparam int F_RLD = 1;
  localparam int F_CMP = 2;
  localparam int F_EN  = 3;
  localparam int NF    = 4;
endpackage

// File: rtl/wdg_field_sync.sv
module wdg_field_sync #(
  parameter int W   = 12,
  parameter int LAT = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         busy_o
);
  localparam int LW = $clog2(LAT + 1);
  localparam logic [LW-1:0] LAT_V = LW'(LAT);

  logic [LW-1:0] cnt_q;
  logic [W-1:0]  sh_q, act_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      sh_q  <= INIT;
      act_q <= INIT;
    end else if (load_i) begin
      sh_q  <= d_i;
      cnt_q <= LAT_V;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LW'(1);
      if (cnt_q == LW'(1)) act_q <= sh_q;
    end
  end

  assign shadow_o = sh_q;
  assign active_o = act_q;
  assign busy_o   = (cnt_q != '0);

  // R7
  busy_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAT_V);
  // R7
  settled_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> (act_q == sh_q));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int CODE_W     = 12,
  parameter int BASE_SHIFT = 2,
  parameter int MAX_SHIFT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int PRE_W = BASE_SHIFT + MAX_SHIFT;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] top_v;
  int               sh;

  always_comb begin
    sh    = (code_i >= CODE_W'(MAX_SHIFT)) ? MAX_SHIFT : int'(code_i);
    top_v = PRE_W'((1 << (BASE_SHIFT + sh)) - 1);
  end

  assign tick_o = run_i && !clr_i && (pre_q >= top_v);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i || !run_i || tick_o) pre_q <= '0;
    else                                   pre_q <= pre_q + PRE_W'(1);
  end

  // R4
  idle_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/wdg_down.sv
module wdg_down #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             en_i,
  input  logic             ack_i,
  output logic             pulse_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q, flag_q, irq_q;
  logic             step, hit, flag_d;

  assign step   = run_i && tick_i && !load_i;
  assign hit    = step && (cnt_q != '0) && ((cnt_q - CNT_W'(1)) == cmp_i);
  assign flag_d = hit || (flag_q && !ack_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '1;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pulse_q <= step && (cnt_q == '0);
      flag_q  <= flag_d;
      irq_q   <= flag_d && en_i;
      if (load_i)                 cnt_q <= rld_i;
      else if (step) cnt_q <= (cnt_q == '0) ? rld_i : cnt_q - CNT_W'(1);
    end
  end

  assign pulse_o = pulse_q;
  assign flag_o  = flag_q;
  assign irq_o   = irq_q;

  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_q |=> !pulse_q);
  // R8
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q |-> flag_q);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int LAT     = 8,
  parameter logic [7:0] VERSION = 8'h40
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdg_rst_o,
  output logic              ew_irq_o
);
  localparam logic [NF-1:0][CNT_W-1:0] FLD_INIT =
    {CNT_W'(0), CNT_W'(0), {CNT_W{1'b1}}, CNT_W'(0)};

  logic open_q, run_q;
  logic [DATA_W-1:0] rdata_q;
  logic wr_key, wr_pre, wr_rld, wr_ew, wr_clr;
  logic key_start, key_reload, ack, load, tick, flag;

  logic [NF-1:0]            fld_wr, busy;
  logic [NF-1:0][CNT_W-1:0] fld_d, fld_sh, fld_act;

  assign wr_key = wr_en_i && (addr_i == A_KEY);
  assign wr_pre = wr_en_i && (addr_i == A_PRE);
  assign wr_rld = wr_en_i && (addr_i == A_RLD);
  assign wr_ew  = wr_en_i && (addr_i == A_EW);
  assign wr_clr = wr_en_i && (addr_i == A_CLR);

  assign key_start  = wr_key && (wdata_i == K_START);
  assign key_reload = wr_key && (wdata_i == K_RELOAD);
  assign ack  = (wr_ew && wdata_i[14]) || (wr_clr && wdata_i[15]);
  assign load = key_start || key_reload || (wr_ew && open_q);

  always_comb begin
    fld_wr[F_PRE] = wr_pre && open_q;
    fld_wr[F_RLD] = wr_rld && open_q;
    fld_wr[F_CMP] = wr_ew && open_q;
    fld_wr[F_EN]  = wr_ew && open_q;
    fld_d[F_PRE]  = CNT_W'(wdata_i[3:0]);
    fld_d[F_RLD]  = CNT_W'(wdata_i[CNT_W-1:0]);
    fld_d[F_CMP]  = CNT_W'(wdata_i[CNT_W-1:0]);
    fld_d[F_EN]   = CNT_W'(wdata_i[15]);
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    wdg_field_sync #(.W(CNT_W), .LAT(LAT), .INIT(FLD_INIT[i])) u_sync (
      .clk_i(clk_i), .rst_i(rst_i), .load_i(fld_wr[i]), .d_i(fld_d[i]),
      .shadow_o(fld_sh[i]), .active_o(fld_act[i]), .busy_o(busy[i]));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      open_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (wr_key && wdata_i == K_OPEN)      open_q <= 1'b1;
      else if (wr_key && wdata_i == K_LOCK) open_q <= 1'b0;
      if (key_start) run_q <= 1'b1;
    end
  end

  wdg_prescaler #(.CODE_W(CNT_W)) u_pre (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run_q), .clr_i(load),
    .code_i(fld_act[F_PRE]), .tick_o(tick));

  wdg_down #(.CNT_W(CNT_W)) u_down (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(run_q), .tick_i(tick),
    .load_i(load), .rld_i(fld_act[F_RLD]), .cmp_i(fld_act[F_CMP]),
    .en_i(|fld_act[F_EN]), .ack_i(ack), .pulse_o(wdg_rst_o),
    .flag_o(flag), .irq_o(ew_irq_o));

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        A_PRE:   rdata_q <= DATA_W'(fld_sh[F_PRE]);
        A_RLD:   rdata_q <= DATA_W'(fld_sh[F_RLD]);
        A_STAT:  rdata_q <= {flag, 6'b0, run_q, 4'b0, busy};
        A_EW:    rdata_q <= {|fld_sh[F_EN], 3'b0, fld_sh[F_CMP]};
        A_VER:   rdata_q <= DATA_W'(VERSION);
        default: rdata_q <= '0;
      endcase
    end
  end
  assign rdata_o = rdata_q;

  // R11
  never_stops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q |=> run_q);
  // R2
  start_runs_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    key_start |=> run_q);
  // R6
  locked_no_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_rld && !open_q && !busy[F_RLD]) |=> !busy[F_RLD]);
endmodule

// File: tb/wdg_top_test.sv
`timescale 1ns/1ps
module wdg_top_test;
  logic clk = 1'b0, rst = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic wrst, irq;
  int checks = 0, fails = 0, cyc = 0;
  longint t_wr;

  always #4 clk = ~clk;

  wdg_top uut (.clk_i(clk), .rst_i(rst), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wdg_rst_o(wrst),
    .ew_irq_o(irq));

  function automatic int divf(int code);
    return 4 << ((code >= 6) ? 6 : code);
  endfunction
  function automatic int periodf(int rl, int code);
    return (rl + 1) * divf(code);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [11:0] a, logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); t_wr = $time;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic brd(logic [11:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_sig(bit which_irq, output longint t);
    t = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ((which_irq ? irq : wrst) === 1'b1) begin t = $time - 4; break; end
    end
  endtask

  task automatic hard_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  task automatic setup(int code, int rl, int cmp, bit en);
    hard_reset();
    bwr(12'h000, 16'h5555);
    bwr(12'h004, 16'(code));
    bwr(12'h008, 16'(rl));
    bwr(12'h014, {en, 3'b0, 12'(cmp)});
    repeat (12) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    longint t0, t1, t2;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk); rst = 1'b0;

    // R1 reset state
    brd(12'h00C, d); chk("R1 status", d, 0);
    brd(12'h008, d); chk("R1 reload", d, 16'hFFF);
    brd(12'h004, d); chk("R1 prescaler", d, 0);
    brd(12'h014, d); chk("R1 early", d, 0);
    chk("R1 outputs", {wrst, irq}, 0);
    // R12
    brd(12'h3F4, d); chk("R12 version", d[7:0], 8'h40);

    // R2 / R3 basic period, repeating
    setup(0, 20, 0, 0);
    bwr(12'h000, 16'hCCCC); t0 = t_wr;
    brd(12'h00C, d); chk("R2 running", d[8], 1);
    wait_sig(0, t1); chk("R3 first period", (t1 - t0) / 8, periodf(20, 0));
    @(negedge clk); chk("R3 one cycle", wrst, 0);
    wait_sig(0, t2); chk("R3 repeat period", (t2 - t1) / 8, periodf(20, 0));

    // R4 / R8 random configurations
    for (int it = 0; it < 6; it++) begin
      int rl, code, cmp;
      rl = 8 + int'($urandom % 24); code = int'($urandom % 3);
      cmp = int'($urandom % rl);
      setup(code, rl, cmp, 1);
      bwr(12'h000, 16'hCCCC); t0 = t_wr;
      wait_sig(1, t1);
      chk("R8 warning time", (t1 - t0) / 8, (rl - cmp) * divf(code));
      wait_sig(0, t2);
      chk("R4 period", (t2 - t0) / 8, periodf(rl, code));
    end

    // R4 saturating code
    setup(9, 2, 0, 0);
    bwr(12'h000, 16'hCCCC); t0 = t_wr;
    wait_sig(0, t1); chk("R4 code 9 -> 256", (t1 - t0) / 8, 3 * 256);

    // R8 flag without enable
    setup(0, 10, 3, 0);
    bwr(12'h000, 16'hCCCC);
    wait_sig(0, t1);
    brd(12'h00C, d); chk("R8 flag set", d[15], 1);
    chk("R8 irq masked", irq, 0);

    // R9 acknowledge paths
    setup(0, 20, 5, 1);
    bwr(12'h000, 16'hCCCC);
    wait_sig(1, t1);
    bwr(12'h000, 16'h0000);
    bwr(12'h014, 16'h4000);
    brd(12'h00C, d); chk("R9 locked ack flag", d[15], 0);
    chk("R9 locked ack irq", irq, 0);
    wait_sig(1, t1);
    bwr(12'h018, 16'h8000);
    brd(12'h00C, d); chk("R9 clear reg flag", d[15], 0);
    chk("R9 clear reg irq", irq, 0);

    // R7 stale reload while busy, R5 reload key
    setup(0, 10, 0, 0);
    bwr(12'h000, 16'hCCCC);
    bwr(12'h008, 16'd50);
    brd(12'h00C, d); chk("R7 reload busy", d[3:0], 4'b0010);
    bwr(12'h000, 16'hAAAA); t0 = t_wr;
    wait_sig(0, t1); chk("R5 R7 old reload used", (t1 - t0) / 8, periodf(10, 0));
    brd(12'h00C, d); chk("R7 busy cleared", d[3:0], 0);
    wait_sig(0, t2); chk("R7 new reload used", (t2 - t1) / 8, periodf(50, 0));

    // R6 locked writes ignored
    bwr(12'h000, 16'h0000);
    bwr(12'h008, 16'd5);
    brd(12'h00C, d); chk("R6 no busy", d[3:0], 0);
    brd(12'h008, d); chk("R6 value kept", d, 50);

    // R10 locked early write no reload, open one reloads
    wait_sig(0, t1);
    repeat (60) @(negedge clk);
    bwr(12'h014, 16'h0000);
    wait_sig(0, t2); chk("R10 locked no reload", (t2 - t1) / 8, periodf(50, 0));
    bwr(12'h000, 16'h5555);
    repeat (60) @(negedge clk);
    bwr(12'h014, 16'h0000); t0 = t_wr;
    wait_sig(0, t2); chk("R10 open reloads", (t2 - t0) / 8, periodf(50, 0));

    // R11 keys do not stop it
    bwr(12'h000, 16'h0000);
    bwr(12'h000, 16'h1234);
    brd(12'h00C, d); chk("R11 still running", d[8], 1);
    wait_sig(0, t1); chk("R11 pulse still comes", t1 > 0, 1);
    hard_reset();
    brd(12'h00C, d); chk("R11 reset stops", d[8], 0);

    finish_run();
  end
endmodule